// File: doc/BRIEF.md
# Serial EEPROM Write Guard

This block decides, once per serial frame, whether a write into a serial EEPROM may begin. The serial front end reports the frame: the decoded instruction kind, how many clock bits the host shifted before chip select rose, a one-cycle pulse when chip select rises, and the start address of a memory write. The guard combines that with the write-protect pin and the stored protection bits (hardware-lock enable and the two block-lock bits). It then issues a one-cycle grant for either the array or the status register.

The guard owns the write-enable latch and the write-in-progress flag. Only a correctly terminated enable instruction sets the latch. A write is granted only while the latch is set, the frame ended on a legal bit count, and the target is not protected. A granted write raises the busy flag. The memory side's completion pulse then drops the busy flag and the latch together. While busy, every instruction event is ignored.

Top module: `wpGuard`

## Requirements
- R1: After reset the latch output `wel`, the busy output `wip` and both grant outputs are 0.
- R2: An enable frame (`cmdKind` = 1) sets `wel` only when `csRise` arrives with `bitCount` exactly 8. Any other count leaves `wel` unchanged.
- R3: A disable frame (`cmdKind` = 2) ending at `bitCount` 8 clears `wel`.
- R4: An array write frame (`cmdKind` = 3) is granted only if `wel` is 1 and `bitCount` is at least 32 and a multiple of 8. The grant is `memGrant` high for one cycle, and `wip` rises in the same cycle.
- R5: With a 15-bit address, the block-lock bits `bpBits` protect these regions: 00 nothing, 01 0x6000–0x7FFF, 10 0x4000–0x7FFF, 11 the whole array. An array write that starts inside a protected region is refused.
- R6: A status write frame (`cmdKind` = 4) ending at `bitCount` 16 with `wel` set is granted through `statGrant`, unless `wpPin` is 0 and `wpenBit` is 1. In that case it is refused.
- R7: When `wpPin` is 0 and `wpenBit` is 1, array writes outside the protected region are still granted.
- R8: A refused write leaves `wel` unchanged and leaves `wip` at 0.
- R9: A `cycleDone` pulse while `wip` is 1 clears both `wip` and `wel` on the next edge.
- R10: While `wip` is 1, instruction events are ignored. This includes an event whose `csRise` falls in the same cycle as `cycleDone`.
- R11: An instruction kind presented without `csRise` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csRise | input | 1 | One-cycle pulse: chip select went high, frame ended |
| cmdKind | input | 3 | Decoded instruction: 0 none, 1 enable, 2 disable, 3 array write, 4 status write |
| bitCount | input | 12 | Clock bits shifted in the ending frame |
| wrAddr | input | 15 | Start address of an array write |
| wpPin | input | 1 | Write-protect pin level (0 = asserted) |
| wpenBit | input | 1 | Stored hardware-lock enable bit |
| bpBits | input | 2 | Stored block-lock bits |
| cycleDone | input | 1 | Pulse from the memory side: write cycle finished |
| wel | output | 1 | Write-enable latch |
| wip | output | 1 | Write in progress |
| memGrant | output | 1 | One-cycle grant to start an array write |
| statGrant | output | 1 | One-cycle grant to start a status write |

## Verification
A write cycle can finish in the same cycle that a new frame ends, so the completion pulse and an instruction event can share one cycle. The bench provokes this by starting a granted write and then driving `cycleDone` together with an enable frame ending at bit 8. Because the part is still busy in that cycle, the expected result is `wip` and `wel` both 0 on the next edge. A second case drives a disable frame during a busy period and expects `wel` to stay set until completion.

// File: rtl/wpGuardPkg.sv
package wpGuardPkg;
  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_WREN = 3'd1,
    CMD_WRDI = 3'd2,
    CMD_MEM  = 3'd3,
    CMD_STAT = 3'd4
  } cmdKind_e;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic startMem;
    logic startStat;
    logic finish;
  } guardStrobe_t;
endpackage

// File: rtl/wpGuardCtl.sv
module wpGuardCtl
  import wpGuardPkg::*;
#(
  parameter int CNTW       = 12,
  parameter int OP_BITS    = 8,
  parameter int ADDR_FRAME = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic            csRise,
  input  logic [2:0]      cmdKind,
  input  logic [CNTW-1:0] bitCount,
  input  logic            cycleDone,
  input  logic            wel,
  input  logic            wip,
  input  logic            memBlocked,
  input  logic            statLocked,
  output guardStrobe_t    strobe
);
  localparam int MEM_MIN  = OP_BITS + ADDR_FRAME + DATA_BITS;
  localparam int STAT_LEN = OP_BITS + DATA_BITS;

  cmdKind_e kind;
  logic     opCountOk, memCountOk, statCountOk, live;

  always_comb begin
    kind        = cmdKind_e'(cmdKind);
    opCountOk   = (bitCount == CNTW'(OP_BITS));
    statCountOk = (bitCount == CNTW'(STAT_LEN));
    memCountOk  = (bitCount >= CNTW'(MEM_MIN)) &&
                  ((bitCount % CNTW'(DATA_BITS)) == '0);
    live        = csRise && !wip;

    strobe           = '0;
    strobe.finish    = wip && cycleDone;
    if (live) begin
      unique case (kind)
        CMD_WREN: strobe.setWel    = opCountOk;
        CMD_WRDI: strobe.clrWel    = opCountOk;
        CMD_MEM:  strobe.startMem  = wel && memCountOk && !memBlocked;
        CMD_STAT: strobe.startStat = wel && statCountOk && !statLocked;
        default: ;
      endcase
    end
    if (strobe.finish) strobe.clrWel = 1'b1;
  end
endmodule

// File: rtl/wpGuardDp.sv
module wpGuardDp
  import wpGuardPkg::*;
#(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rstN,
  input  guardStrobe_t  strobe,
  input  logic          wpPin,
  input  logic          wpenBit,
  input  logic [1:0]    bpBits,
  input  logic [AW-1:0] wrAddr,
  output logic          memBlocked,
  output logic          statLocked,
  output logic          wel,
  output logic          wip,
  output logic          memGrant,
  output logic          statGrant
);
  logic [1:0] quarter;

  always_comb begin
    quarter    = wrAddr[AW-1 -: 2];
    statLocked = !wpPin && wpenBit;
    unique case (bpBits)
      2'b00:   memBlocked = 1'b0;
      2'b01:   memBlocked = (quarter == 2'b11);
      2'b10:   memBlocked = quarter[1];
      default: memBlocked = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel       <= 1'b0;
      wip       <= 1'b0;
      memGrant  <= 1'b0;
      statGrant <= 1'b0;
    end else begin
      if (strobe.clrWel)      wel <= 1'b0;
      else if (strobe.setWel) wel <= 1'b1;
      if (strobe.finish)                            wip <= 1'b0;
      else if (strobe.startMem || strobe.startStat) wip <= 1'b1;
      memGrant  <= strobe.startMem;
      statGrant <= strobe.startStat;
    end
  end
endmodule

// File: rtl/wpGuard.sv
module wpGuard
  import wpGuardPkg::*;
#(
  parameter int CNTW       = 12,
  parameter int AW         = 15,
  parameter int OP_BITS    = 8,
  parameter int ADDR_FRAME = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csRise,
  input  logic [2:0]      cmdKind,
  input  logic [CNTW-1:0] bitCount,
  input  logic [AW-1:0]   wrAddr,
  input  logic            wpPin,
  input  logic            wpenBit,
  input  logic [1:0]      bpBits,
  input  logic            cycleDone,
  output logic            wel,
  output logic            wip,
  output logic            memGrant,
  output logic            statGrant
);
  guardStrobe_t strobe;
  logic         memBlocked, statLocked;

  wpGuardCtl #(.CNTW(CNTW), .OP_BITS(OP_BITS), .ADDR_FRAME(ADDR_FRAME),
               .DATA_BITS(DATA_BITS)) u_ctl (
    .csRise(csRise), .cmdKind(cmdKind), .bitCount(bitCount),
    .cycleDone(cycleDone), .wel(wel), .wip(wip),
    .memBlocked(memBlocked), .statLocked(statLocked), .strobe(strobe)
  );

  wpGuardDp #(.AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wpPin(wpPin),
    .wpenBit(wpenBit), .bpBits(bpBits), .wrAddr(wrAddr),
    .memBlocked(memBlocked), .statLocked(statLocked),
    .wel(wel), .wip(wip), .memGrant(memGrant), .statGrant(statGrant)
  );
endmodule

// File: rtl/wpGuardChk.sv
module wpGuardChk (
  input logic       clk,
  input logic       rstN,
  input logic       wpPin,
  input logic       wpenBit,
  input logic [1:0] bpBits,
  input logic       cycleDone,
  input logic       wel,
  input logic       wip,
  input logic       memGrant,
  input logic       statGrant
);
  a_r1_single_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memGrant, statGrant}));
  a_r4_grant_needs_latch: assert property (@(posedge clk) disable iff (!rstN)
    memGrant |-> ($past(wel) && wip));
  a_r5_full_lock: assert property (@(posedge clk) disable iff (!rstN)
    memGrant |-> ($past(bpBits) != 2'b11));
  a_r6_status_lock: assert property (@(posedge clk) disable iff (!rstN)
    statGrant |-> ($past(wpPin) || !$past(wpenBit)));
  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wip && cycleDone) |=> (!wip && !wel));
  a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wip && !cycleDone) |=> (wip && $stable(wel)));
endmodule

bind wpGuard wpGuardChk u_chk (
  .clk(clk), .rstN(rstN), .wpPin(wpPin), .wpenBit(wpenBit), .bpBits(bpBits),
  .cycleDone(cycleDone), .wel(wel), .wip(wip), .memGrant(memGrant),
  .statGrant(statGrant)
);

// File: tb/wpGuard_tb.sv
module wpGuard_tb;
  localparam time CLK_PERIOD = 20ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csRise = 1'b0;
  logic [2:0]  cmdKind = 3'd0;
  logic [11:0] bitCount = '0;
  logic [14:0] wrAddr = '0;
  logic        wpPin = 1'b1;
  logic        wpenBit = 1'b0;
  logic [1:0]  bpBits = 2'b00;
  logic        cycleDone = 1'b0;
  logic        wel, wip, memGrant, statGrant;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wpGuard u_dut (
    .clk(clk), .rstN(rstN), .csRise(csRise), .cmdKind(cmdKind),
    .bitCount(bitCount), .wrAddr(wrAddr), .wpPin(wpPin), .wpenBit(wpenBit),
    .bpBits(bpBits), .cycleDone(cycleDone), .wel(wel), .wip(wip),
    .memGrant(memGrant), .statGrant(statGrant)
  );

  typedef struct packed {
    logic        wp;
    logic        wpen;
    logic [1:0]  bp;
    logic [2:0]  cmd;
    logic [11:0] cnt;
    logic [14:0] addr;
    logic        pre;
    logic        expM;
    logic        expS;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 2'd0, 3'd3, 12'd32, 15'h0000, 1'b1, 1'b1, 1'b0},  // R4
    '{1'b1, 1'b0, 2'd0, 3'd3, 12'd40, 15'h1234, 1'b1, 1'b1, 1'b0},  // R4
    '{1'b1, 1'b0, 2'd0, 3'd3, 12'd36, 15'h0010, 1'b1, 1'b0, 1'b0},  // R4
    '{1'b1, 1'b0, 2'd0, 3'd3, 12'd24, 15'h0010, 1'b1, 1'b0, 1'b0},  // R4
    '{1'b1, 1'b0, 2'd0, 3'd3, 12'd32, 15'h0010, 1'b0, 1'b0, 1'b0},  // R8
    '{1'b1, 1'b0, 2'd1, 3'd3, 12'd32, 15'h6000, 1'b1, 1'b0, 1'b0},  // R5
    '{1'b1, 1'b0, 2'd1, 3'd3, 12'd32, 15'h5FFF, 1'b1, 1'b1, 1'b0},  // R5
    '{1'b1, 1'b0, 2'd2, 3'd3, 12'd32, 15'h4000, 1'b1, 1'b0, 1'b0},  // R5
    '{1'b1, 1'b0, 2'd2, 3'd3, 12'd32, 15'h3FFF, 1'b1, 1'b1, 1'b0},  // R5
    '{1'b1, 1'b0, 2'd3, 3'd3, 12'd32, 15'h0000, 1'b1, 1'b0, 1'b0},  // R5
    '{1'b0, 1'b1, 2'd0, 3'd4, 12'd16, 15'h0000, 1'b1, 1'b0, 1'b0},  // R6
    '{1'b1, 1'b1, 2'd0, 3'd4, 12'd16, 15'h0000, 1'b1, 1'b0, 1'b1},  // R6
    '{1'b0, 1'b0, 2'd0, 3'd4, 12'd16, 15'h0000, 1'b1, 1'b0, 1'b1},  // R6
    '{1'b0, 1'b1, 2'd1, 3'd3, 12'd32, 15'h0100, 1'b1, 1'b1, 1'b0},  // R7
    '{1'b0, 1'b1, 2'd1, 3'd3, 12'd32, 15'h7000, 1'b1, 1'b0, 1'b0},  // R7
    '{1'b1, 1'b0, 2'd0, 3'd4, 12'd24, 15'h0000, 1'b1, 1'b0, 1'b0}   // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [2:0] k, input int cnt, input logic [14:0] a);
    @(negedge clk);
    cmdKind = k; bitCount = 12'(cnt); wrAddr = a; csRise = 1'b1;
    @(negedge clk);
    csRise = 1'b0; cmdKind = 3'd0;
  endtask

  task automatic finishCycle();
    @(negedge clk);
    cycleDone = 1'b1;
    @(negedge clk);
    cycleDone = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 wel", wel, 0);
    check("R1 wip", wip, 0);
    check("R1 grants", {memGrant, statGrant}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {wel, wip, memGrant, statGrant}, 0);

    foreach (VECS[i]) begin
      wpPin = VECS[i].wp; wpenBit = VECS[i].wpen; bpBits = VECS[i].bp;
      if (VECS[i].pre) begin
        frame(3'd1, 8, '0);
        check("R2 enable", wel, 1);
      end
      frame(VECS[i].cmd, int'(VECS[i].cnt), VECS[i].addr);
      check($sformatf("R4 R5 R7 mem grant vec %0d", i), memGrant, VECS[i].expM);
      check($sformatf("R6 status grant vec %0d", i), statGrant, VECS[i].expS);
      if (VECS[i].expM || VECS[i].expS) begin
        check("R4 wip set", wip, 1);
        @(negedge clk);
        check("R4 grant one cycle", {memGrant, statGrant}, 0);
        finishCycle();
        check("R9 done clears", {wip, wel}, 0);
      end else begin
        check("R8 refused keeps latch", wel, VECS[i].pre);
        check("R8 refused no busy", wip, 0);
        frame(3'd2, 8, '0);
        check("R3 disable", wel, 0);
      end
    end

    wpPin = 1'b1; wpenBit = 1'b0; bpBits = 2'b00;
    frame(3'd1, 9, '0);
    check("R2 late raise ignored", wel, 0);
    frame(3'd1, 16, '0);
    check("R2 long frame ignored", wel, 0);

    @(negedge clk);
    cmdKind = 3'd1; bitCount = 12'd8;
    repeat (2) @(negedge clk);
    cmdKind = 3'd0;
    check("R11 no csRise", wel, 0);

    frame(3'd1, 8, '0);
    frame(3'd3, 32, 15'h0040);
    check("R4 granted before busy test", wip, 1);
    frame(3'd2, 8, '0);
    check("R10 disable ignored while busy", wel, 1);
    frame(3'd3, 32, 15'h0080);
    check("R10 no grant while busy", memGrant, 0);

    @(negedge clk);
    cycleDone = 1'b1; csRise = 1'b1; cmdKind = 3'd1; bitCount = 12'd8;
    @(negedge clk);
    cycleDone = 1'b0; csRise = 1'b0; cmdKind = 3'd0;
    check("R10 coincident enable ignored", {wip, wel}, 0);
    frame(3'd1, 8, '0);
    check("R2 enable after busy", wel, 1);

    summary();
  end
endmodule